// File: doc/BRIEF.md
# SHA-2 Dual-Round Compression Step

This block advances a SHA-2 working state by two compression rounds in a single operation. The eight state variables arrive as two four-element groups: one holds {h, g, d, c} and the other holds {f, e, b, a}. A third four-element group carries four precomputed round-constant-plus-schedule sums. A half select decides which adjacent pair of those sums the two rounds use. Only the {f, e, b, a} part of the result is returned. The surrounding sequencer keeps the other half by rotating its registers between calls.

A two-bit element-width code chooses the word size. Code 2 selects 32-bit words (SHA-256). Code 3 selects 64-bit words (SHA-512). Codes 0 and 1 are illegal. Both rounds are evaluated in one combinational path and captured in an output register. The result is therefore presented one cycle after the request.

Top module: `sha2_compress_pair`

## Requirements
- R1: In group `cdgh_grp`, element i occupies bits [i*W +: W], where W is 32 or 64. Element 0 is h, element 1 is g, element 2 is d and element 3 is c.
- R2: In group `abef_grp`, using the same element placement, element 0 is f, element 1 is e, element 2 is b and element 3 is a.
- R3: When `hi_sel` is 0, the first round uses `kw_grp` element 0 and the second round uses element 1. Elements 2 and 3 have no effect on the result.
- R4: When `hi_sel` is 1, the first round uses element 2 and the second round uses element 3. Elements 0 and 1 have no effect on the result.
- R5: Each round computes T1 = h + S1(e) + Ch(e,f,g) + kw and T2 = S0(a) + Maj(a,b,c), with all sums taken modulo 2^W. It then sets a=T1+T2, b=a, c=b, d=c, e=d+T1, f=e, g=f and h=g. Here Ch = (x&y)^(~x&z) and Maj = (x&y)^(x&z)^(y&z).
- R6: With `sew_code` = 2, words are 32 bits wide. S0 rotates right by 2, 13 and 22, and S1 rotates right by 6, 11 and 25. Input bits 255:128 are ignored, and `abef_out` bits 255:128 are zero.
- R7: With `sew_code` = 3, words are 64 bits wide. S0 rotates right by 28, 34 and 39, and S1 rotates right by 14, 18 and 41.
- R8: `abef_out` returns the new f, e, b and a in elements 0 to 3. The new c, d, g and h are dropped.
- R9: A request with `sew_code` 0 or 1 gives `out_err` = 1 and `abef_out` = 0. A request with code 2 or 3 gives `out_err` = 0.
- R10: `out_valid` is high exactly in the cycle after a cycle in which `in_valid` was high. Without `in_valid`, `abef_out` and `out_err` hold their values.
- R11: After synchronous reset, `out_valid`, `out_err` and `abef_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| sew_code | input | 2 | Element width code (2 = 32-bit, 3 = 64-bit) |
| hi_sel | input | 1 | Selects K+W elements 2,3 when 1, else 0,1 |
| cdgh_grp | input | 256 | State group {c,d,g,h}, h in element 0 |
| abef_grp | input | 256 | State group {a,b,e,f}, f in element 0 |
| kw_grp | input | 256 | Four K+W sums |
| out_valid | output | 1 | Result valid |
| out_err | output | 1 | Illegal width code was requested |
| abef_out | output | 256 | Updated {a,b,e,f} group, f in element 0 |

## Verification
The checker watches the protocol and the error reporting on every cycle. It covers the one-cycle valid latency, holding of the output between requests, the error flag for each code class, a zeroed output on error, and a zero upper half in 32-bit mode. The arithmetic can only be shown by the bench's sweeps. These cover the round equations, the rotation amounts for each word size, the element placement, and the order in which the two K+W sums are consumed. The bench compares results against an independent model over many patterns in both modes and both halves. It also perturbs the unused K+W elements and the ignored upper input bits to show they have no effect.

// File: rtl/sha2c_pkg.sv
package sha2c_pkg;

    localparam int WORD_MAX  = 64;
    localparam int NUM_ELEMS = 4;
    localparam int GRP_W     = WORD_MAX * NUM_ELEMS;
    localparam int NUM_RNDS  = 2;

    typedef logic [WORD_MAX-1:0] word_t;

    typedef enum logic [1:0] {
        SEW_8  = 2'd0,
        SEW_16 = 2'd1,
        SEW_32 = 2'd2,
        SEW_64 = 2'd3
    } sew_e;

    typedef struct packed {
        word_t a;
        word_t b;
        word_t c;
        word_t d;
        word_t e;
        word_t f;
        word_t g;
        word_t h;
    } work_t;

    function automatic word_t wmask(input word_t x, input logic is64);
        return is64 ? x : {32'b0, x[31:0]};
    endfunction

    function automatic word_t rotr64(input word_t x, input int n);
        return (x >> n) | (x << (64 - n));
    endfunction

    function automatic logic [31:0] rotr32(input logic [31:0] x, input int n);
        return (x >> n) | (x << (32 - n));
    endfunction

    function automatic word_t big_sig0(input word_t x, input logic is64);
        if (is64)
            return rotr64(x, 28) ^ rotr64(x, 34) ^ rotr64(x, 39);
        return {32'b0, rotr32(x[31:0], 2) ^ rotr32(x[31:0], 13) ^ rotr32(x[31:0], 22)};
    endfunction

    function automatic word_t big_sig1(input word_t x, input logic is64);
        if (is64)
            return rotr64(x, 14) ^ rotr64(x, 18) ^ rotr64(x, 41);
        return {32'b0, rotr32(x[31:0], 6) ^ rotr32(x[31:0], 11) ^ rotr32(x[31:0], 25)};
    endfunction

    function automatic word_t choose(input word_t x, input word_t y, input word_t z);
        return (x & y) ^ (~x & z);
    endfunction

    function automatic word_t majority(input word_t x, input word_t y, input word_t z);
        return (x & y) ^ (x & z) ^ (y & z);
    endfunction

endpackage

// File: rtl/sha2c_unpack.sv
module sha2c_unpack
    import sha2c_pkg::*;
(
    input  logic             is64,
    input  logic             hi_sel,
    input  logic [GRP_W-1:0] cdgh_grp,
    input  logic [GRP_W-1:0] abef_grp,
    input  logic [GRP_W-1:0] kw_grp,
    output work_t            st,
    output word_t            kw_seq [NUM_RNDS]
);

    word_t cdgh_e [NUM_ELEMS];
    word_t abef_e [NUM_ELEMS];
    word_t kw_e   [NUM_ELEMS];

    for (genvar i = 0; i < NUM_ELEMS; i++) begin : g_elem
        assign cdgh_e[i] = is64 ? cdgh_grp[i*64 +: 64] : {32'b0, cdgh_grp[i*32 +: 32]};
        assign abef_e[i] = is64 ? abef_grp[i*64 +: 64] : {32'b0, abef_grp[i*32 +: 32]};
        assign kw_e[i]   = is64 ? kw_grp[i*64 +: 64]   : {32'b0, kw_grp[i*32 +: 32]};
    end

    always_comb begin
        st.h = cdgh_e[0];
        st.g = cdgh_e[1];
        st.d = cdgh_e[2];
        st.c = cdgh_e[3];
        st.f = abef_e[0];
        st.e = abef_e[1];
        st.b = abef_e[2];
        st.a = abef_e[3];
    end

    for (genvar r = 0; r < NUM_RNDS; r++) begin : g_kw
        assign kw_seq[r] = hi_sel ? kw_e[NUM_RNDS + r] : kw_e[r];
    end

endmodule

// File: rtl/sha2c_round.sv
module sha2c_round
    import sha2c_pkg::*;
(
    input  logic  is64,
    input  work_t st_in,
    input  word_t kw,
    output work_t st_out
);

    word_t t1;
    word_t t2;

    always_comb begin
        t1 = wmask(st_in.h + big_sig1(st_in.e, is64)
                   + choose(st_in.e, st_in.f, st_in.g) + kw, is64);
        t2 = wmask(big_sig0(st_in.a, is64)
                   + majority(st_in.a, st_in.b, st_in.c), is64);
        st_out.h = st_in.g;
        st_out.g = st_in.f;
        st_out.f = st_in.e;
        st_out.e = wmask(st_in.d + t1, is64);
        st_out.d = st_in.c;
        st_out.c = st_in.b;
        st_out.b = st_in.a;
        st_out.a = wmask(t1 + t2, is64);
    end

endmodule

// File: rtl/sha2_compress_pair.sv
module sha2_compress_pair
    import sha2c_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [1:0]       sew_code,
    input  logic             hi_sel,
    input  logic [GRP_W-1:0] cdgh_grp,
    input  logic [GRP_W-1:0] abef_grp,
    input  logic [GRP_W-1:0] kw_grp,
    output logic             out_valid,
    output logic             out_err,
    output logic [GRP_W-1:0] abef_out
);

    localparam int HALF_W = GRP_W / 2;

    sew_e  sew;
    logic  is64;
    logic  legal;
    work_t stage [NUM_RNDS+1];
    word_t kw_seq [NUM_RNDS];
    logic [GRP_W-1:0] packed_res;

    assign sew   = sew_e'(sew_code);
    assign is64  = (sew == SEW_64);
    assign legal = (sew == SEW_32) || (sew == SEW_64);

    sha2c_unpack u_unpack (
        .is64     (is64),
        .hi_sel   (hi_sel),
        .cdgh_grp (cdgh_grp),
        .abef_grp (abef_grp),
        .kw_grp   (kw_grp),
        .st       (stage[0]),
        .kw_seq   (kw_seq)
    );

    for (genvar r = 0; r < NUM_RNDS; r++) begin : g_rnd
        sha2c_round u_round (
            .is64   (is64),
            .st_in  (stage[r]),
            .kw     (kw_seq[r]),
            .st_out (stage[r+1])
        );
    end

    always_comb begin
        if (!legal)
            packed_res = '0;
        else if (is64)
            packed_res = {stage[NUM_RNDS].a, stage[NUM_RNDS].b,
                          stage[NUM_RNDS].e, stage[NUM_RNDS].f};
        else
            packed_res = {{HALF_W{1'b0}},
                          stage[NUM_RNDS].a[31:0], stage[NUM_RNDS].b[31:0],
                          stage[NUM_RNDS].e[31:0], stage[NUM_RNDS].f[31:0]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_err   <= 1'b0;
            abef_out  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_err  <= !legal;
                abef_out <= packed_res;
            end
        end
    end

endmodule

// File: rtl/sha2c_checker.sv
module sha2c_checker
    import sha2c_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [1:0]       sew_code,
    input logic             hi_sel,
    input logic [GRP_W-1:0] cdgh_grp,
    input logic [GRP_W-1:0] abef_grp,
    input logic [GRP_W-1:0] kw_grp,
    input logic             out_valid,
    input logic             out_err,
    input logic [GRP_W-1:0] abef_out
);

    assert_valid_follows_R10: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_no_spurious_valid_R10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_hold_when_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(abef_out) && $stable(out_err)));

    assert_err_on_illegal_R9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && sew_code < 2'd2) |=> out_err);

    assert_no_err_on_legal_R9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && sew_code >= 2'd2) |=> !out_err);

    assert_zero_on_err_R9: assert property (@(posedge clk) disable iff (rst)
        out_err |-> (abef_out == '0));

    assert_upper_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && sew_code == 2'd2) |=> (abef_out[GRP_W-1:GRP_W/2] == '0));

endmodule

bind sha2_compress_pair sha2c_checker u_chk (.*);

// File: tb/tb_sha2_compress_pair.sv
`timescale 1ns/1ps
module tb_sha2_compress_pair;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [1:0]   sew_code;
    logic         hi_sel;
    logic [255:0] cdgh_grp, abef_grp, kw_grp;
    logic         out_valid, out_err;
    logic [255:0] abef_out;

    int total = 0;
    int fails = 0;
    logic [63:0] rng = 64'h9E3779B97F4A7C15;

    always #2 clk = ~clk;

    sha2_compress_pair dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .sew_code(sew_code),
        .hi_sel(hi_sel), .cdgh_grp(cdgh_grp), .abef_grp(abef_grp),
        .kw_grp(kw_grp), .out_valid(out_valid), .out_err(out_err),
        .abef_out(abef_out)
    );

    function automatic logic [63:0] nxt(input logic [63:0] s);
        logic [63:0] x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 7);
        x = x ^ (x << 17);
        return x;
    endfunction

    task automatic rand256(output logic [255:0] v);
        for (int i = 0; i < 4; i++) begin
            rng = nxt(rng);
            v[i*64 +: 64] = rng;
        end
    endtask

    function automatic logic [63:0] rr(input logic [63:0] x, input int n, input bit w64);
        logic [31:0] y;
        if (w64) return (x >> n) | (x << (64 - n));
        y = x[31:0];
        return {32'b0, (y >> n) | (y << (32 - n))};
    endfunction

    function automatic logic [255:0] model(input logic [255:0] cg, input logic [255:0] ag,
                                           input logic [255:0] kg, input bit hi, input bit w64);
        logic [63:0] v [8];
        logic [63:0] k [4];
        logic [63:0] m, s0, s1, chv, mj, t1, t2;
        int w;
        w = w64 ? 64 : 32;
        m = w64 ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
        // v: 0=a 1=b 2=c 3=d 4=e 5=f 6=g 7=h
        for (int i = 0; i < 4; i++) begin
            k[i] = w64 ? kg[i*64 +: 64] : {32'b0, kg[i*32 +: 32]};
        end
        v[7] = w64 ? cg[0 +: 64]   : {32'b0, cg[0 +: 32]};
        v[6] = w64 ? cg[64 +: 64]  : {32'b0, cg[32 +: 32]};
        v[3] = w64 ? cg[128 +: 64] : {32'b0, cg[64 +: 32]};
        v[2] = w64 ? cg[192 +: 64] : {32'b0, cg[96 +: 32]};
        v[5] = w64 ? ag[0 +: 64]   : {32'b0, ag[0 +: 32]};
        v[4] = w64 ? ag[64 +: 64]  : {32'b0, ag[32 +: 32]};
        v[1] = w64 ? ag[128 +: 64] : {32'b0, ag[64 +: 32]};
        v[0] = w64 ? ag[192 +: 64] : {32'b0, ag[96 +: 32]};
        for (int r = 0; r < 2; r++) begin
            if (w64) begin
                s1 = rr(v[4],14,1) ^ rr(v[4],18,1) ^ rr(v[4],41,1);
                s0 = rr(v[0],28,1) ^ rr(v[0],34,1) ^ rr(v[0],39,1);
            end else begin
                s1 = rr(v[4],6,0) ^ rr(v[4],11,0) ^ rr(v[4],25,0);
                s0 = rr(v[0],2,0) ^ rr(v[0],13,0) ^ rr(v[0],22,0);
            end
            chv = ((v[4] & v[5]) ^ (~v[4] & v[6])) & m;
            mj  = (v[0] & v[1]) ^ (v[0] & v[2]) ^ (v[1] & v[2]);
            t1 = (v[7] + s1 + chv + k[hi ? 2 + r : r]) & m;
            t2 = (s0 + mj) & m;
            for (int j = 7; j > 0; j--) v[j] = v[j-1];
            v[4] = (v[4] + t1) & m;
            v[0] = (t1 + t2) & m;
        end
        model = '0;
        if (w64) model = {v[0], v[1], v[4], v[5]};
        else     model = {128'b0, v[0][31:0], v[1][31:0], v[4][31:0], v[5][31:0]};
        if (w != 32 && w != 64) model = '0;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [255:0] act,
                       input logic [255:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] sc, input bit hi, input logic [255:0] cg,
                         input logic [255:0] ag, input logic [255:0] kg);
        @(negedge clk);
        in_valid = 1'b1; sew_code = sc; hi_sel = hi;
        cdgh_grp = cg; abef_grp = ag; kw_grp = kg;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        #700000;
        fails++; total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [255:0] cg, ag, kg, kg2, exp, first;
        rst = 1'b1; in_valid = 1'b0; sew_code = 2'd2; hi_sel = 1'b0;
        cdgh_grp = '0; abef_grp = '0; kw_grp = '0;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(out_valid == 0 && out_err == 0 && abef_out == '0, "R11",
            {254'b0, out_valid, out_err} | abef_out, '0);
        rst = 1'b0;

        // R1 R2 R5 R6 R7 R8: sweep both widths and both halves
        for (int sc = 2; sc < 4; sc++) begin
            for (int hi = 0; hi < 2; hi++) begin
                for (int n = 0; n < 60; n++) begin
                    rand256(cg); rand256(ag); rand256(kg);
                    if (n == 0) begin cg = '0; ag = '0; kg = '0; end
                    if (n == 1) begin cg = '1; ag = '1; kg = '1; end
                    issue(2'(sc), hi[0], cg, ag, kg);
                    exp = model(cg, ag, kg, hi[0], sc == 3);
                    chk(out_valid && !out_err && abef_out == exp,
                        sc == 3 ? "R7/R5/R8 w64" : "R6/R5/R8 w32", abef_out, exp);
                end
            end
        end

        // R3 / R4: unused kw elements have no effect; R6 upper input ignored
        for (int hi = 0; hi < 2; hi++) begin
            for (int n = 0; n < 20; n++) begin
                rand256(cg); rand256(ag); rand256(kg); rand256(kg2);
                issue(2'd3, hi[0], cg, ag, kg);
                first = abef_out;
                if (hi == 0) kg2[127:0] = kg[127:0];
                else         kg2[255:128] = kg[255:128];
                issue(2'd3, hi[0], cg, ag, kg2);
                chk(abef_out == first, hi ? "R4 unused elems" : "R3 unused elems",
                    abef_out, first);
            end
        end
        for (int n = 0; n < 20; n++) begin
            rand256(cg); rand256(ag); rand256(kg);
            issue(2'd2, 1'b0, cg, ag, kg);
            first = abef_out;
            cg[255:128] = ~cg[255:128]; ag[255:128] = ~ag[255:128];
            kg[255:128] = ~kg[255:128];
            issue(2'd2, 1'b0, cg, ag, kg);
            chk(abef_out == first && abef_out[255:128] == '0, "R6 upper ignored",
                abef_out, first);
        end

        // R3 ordering: swapping elements 0 and 1 changes the result generally
        rand256(cg); rand256(ag); rand256(kg);
        kg2 = kg; kg2[63:0] = kg[127:64]; kg2[127:64] = kg[63:0];
        issue(2'd3, 1'b0, cg, ag, kg2);
        exp = model(cg, ag, kg2, 1'b0, 1'b1);
        chk(abef_out == exp && exp != model(cg, ag, kg, 1'b0, 1'b1), "R3 order",
            abef_out, exp);

        // R9 illegal codes
        for (int sc = 0; sc < 2; sc++) begin
            rand256(cg); rand256(ag); rand256(kg);
            issue(2'(sc), 1'b0, cg, ag, kg);
            chk(out_valid && out_err && abef_out == '0, "R9 illegal",
                {255'b0, out_err} | abef_out, 256'b1);
        end
        issue(2'd2, 1'b1, cg, ag, kg);
        chk(!out_err, "R9 clear", {255'b0, out_err}, '0);

        // R10 hold and single-cycle valid
        first = abef_out;
        for (int n = 0; n < 5; n++) begin
            @(negedge clk);
            rand256(cdgh_grp); rand256(abef_grp); rand256(kw_grp);
            sew_code = 2'd0;
            chk(!out_valid && abef_out == first && !out_err, "R10 hold",
                abef_out, first);
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule